// File: doc/BRIEF.md
# Top-Bit Alias Decoder for a RAM/ROM Bus

This block produces device selects and device-local addresses for a small system on a 32-bit byte address bus. The system holds 1 MiB of RAM and 64 KiB of ROM. Only the most significant address bit is decoded: a zero selects RAM and a one selects ROM. The low address bits pass straight through to the selected device. The address bits in between are never examined, so the RAM image repeats every 1 MiB across the lower half of the space. The ROM image repeats every 64 KiB across the upper half, which places a copy of the ROM under the reset vector at 0xFFFFFFF0.

A requester drives an address, a write flag and a request strobe for one cycle. On the next clock edge the block registers the request into an access state. The selects, write enable and local addresses are decoded directly from that state, with no wait states, so they are valid for the whole following cycle. The ROM has no write path. A write aimed at the ROM half still selects the ROM, but it produces no write enable and raises a one-cycle write-ignored flag.

The access state machine has five states: `ST_IDLE` (no access), `ST_RAM_RD`, `ST_RAM_WR`, `ST_ROM_RD` and `ST_ROM_WR`. It is re-evaluated on every edge. If the strobe is low, the next state is `ST_IDLE`. If the strobe is high and bit 31 is 0, the next state is `ST_RAM_WR` for a write or `ST_RAM_RD` for a read. If the strobe is high and bit 31 is 1, the next state is `ST_ROM_WR` for a write or `ST_ROM_RD` for a read. Any state can move to any other on the next edge, so back-to-back requests are decoded one per cycle.

Top module: `alias_decoder`

## Requirements
- R1: While reset is held and in the first cycle after it, `ram_sel_o`, `rom_sel_o`, `ram_we_o` and `rom_wr_ignored_o` are all 0.
- R2: A request sampled with address bit 31 equal to 0 gives `ram_sel_o`=1 and `rom_sel_o`=0 in the following cycle.
- R3: A request sampled with address bit 31 equal to 1 gives `rom_sel_o`=1 and `ram_sel_o`=0 in the following cycle.
- R4: In the cycle after a RAM request, `ram_addr_o` equals address bits [19:0]. Bits [30:20] have no effect, for example 0x00100000 gives 0x00000 and 0x7FF12345 gives 0x12345.
- R5: In the cycle after a ROM request, `rom_addr_o` equals address bits [15:0]. Bits [30:16] have no effect, for example 0xFFFFFFF0 gives 0xFFF0 and 0x8001ABCD gives 0xABCD.
- R6: `ram_we_o` is 1 only in the cycle after a RAM request with `we_i`=1. It is 0 after a RAM read.
- R7: A ROM request with `we_i`=1 gives `rom_sel_o`=1, `ram_we_o`=0 and `rom_wr_ignored_o`=1 for exactly one cycle. A ROM read gives `rom_wr_ignored_o`=0.
- R8: If the strobe is low at an edge, both selects, the write enable and the ignore flag are 0 in the following cycle.
- R9: At most one select is 1 in any cycle. Consecutive requests on consecutive edges are each decoded in the cycle after their own edge, with no inserted wait cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 32 | Byte address |
| ram_sel_o | output | 1 | RAM chip select |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | 20 | RAM local address |
| rom_sel_o | output | 1 | ROM chip select |
| rom_addr_o | output | 16 | ROM local address |
| rom_wr_ignored_o | output | 1 | A write to ROM was dropped |

## Verification
The access state is the only internal memory, and every state maps to its own output pattern. A wrong state therefore shows on the selects, the write enable or the ignore flag in the very cycle after the request that caused it. A state that lingers past its one cycle would show as a stale select or a repeated ignore flag one cycle later, when an idle or different request follows. Alias addresses that set the undecoded middle bits, and requests issued back to back, show any dependence on those bits or any extra delay in the first output cycle.

// File: rtl/alias_dec_pkg.sv
package alias_dec_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RAM_RD = 3'd1,
        ST_RAM_WR = 3'd2,
        ST_ROM_RD = 3'd3,
        ST_ROM_WR = 3'd4
    } acc_state_e;

endpackage

// File: rtl/alias_dec_fsm.sv
module alias_dec_fsm
    import alias_dec_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LOC_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    output acc_state_e        state_o,
    output logic [LOC_W-1:0]  loc_o
);

    localparam int DEC_BIT = ADDR_W - 1;

    acc_state_e state_q, state_d;
    logic [LOC_W-1:0] loc_q;

    // middle bits are deliberately not decoded
    logic unused_mid;
    assign unused_mid = ^addr_i[DEC_BIT-1:LOC_W];

    always_comb begin
        state_d = ST_IDLE;
        if (req_i) begin
            unique case ({addr_i[DEC_BIT], we_i})
                2'b00:   state_d = ST_RAM_RD;
                2'b01:   state_d = ST_RAM_WR;
                2'b10:   state_d = ST_ROM_RD;
                2'b11:   state_d = ST_ROM_WR;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            loc_q   <= '0;
        end else begin
            state_q <= state_d;
            if (req_i) begin
                loc_q <= addr_i[LOC_W-1:0];
            end
        end
    end

    assign state_o = state_q;
    assign loc_o   = loc_q;

endmodule

// File: rtl/alias_dec_out.sv
module alias_dec_out
    import alias_dec_pkg::*;
#(
    parameter int RAM_AW = 20,
    parameter int ROM_AW = 16,
    parameter int LOC_W  = 20
) (
    input  acc_state_e        state_i,
    input  logic [LOC_W-1:0]  loc_i,
    output logic              ram_sel_o,
    output logic              ram_we_o,
    output logic [RAM_AW-1:0] ram_addr_o,
    output logic              rom_sel_o,
    output logic [ROM_AW-1:0] rom_addr_o,
    output logic              rom_wr_ignored_o
);

    always_comb begin
        ram_sel_o        = 1'b0;
        ram_we_o         = 1'b0;
        rom_sel_o        = 1'b0;
        rom_wr_ignored_o = 1'b0;
        unique case (state_i)
            ST_IDLE: ;
            ST_RAM_RD: ram_sel_o = 1'b1;
            ST_RAM_WR: begin
                ram_sel_o = 1'b1;
                ram_we_o  = 1'b1;
            end
            ST_ROM_RD: rom_sel_o = 1'b1;
            ST_ROM_WR: begin
                rom_sel_o        = 1'b1;
                rom_wr_ignored_o = 1'b1;
            end
            default: ;
        endcase
    end

    assign ram_addr_o = loc_i[RAM_AW-1:0];
    assign rom_addr_o = loc_i[ROM_AW-1:0];

endmodule

// File: rtl/alias_decoder.sv
module alias_decoder
    import alias_dec_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int RAM_AW = 20,
    parameter int ROM_AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              ram_sel_o,
    output logic              ram_we_o,
    output logic [RAM_AW-1:0] ram_addr_o,
    output logic              rom_sel_o,
    output logic [ROM_AW-1:0] rom_addr_o,
    output logic              rom_wr_ignored_o
);

    localparam int LOC_W = (RAM_AW > ROM_AW) ? RAM_AW : ROM_AW;

    acc_state_e       state;
    logic [LOC_W-1:0] loc;

    alias_dec_fsm #(
        .ADDR_W(ADDR_W),
        .LOC_W (LOC_W)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req_i),
        .we_i   (we_i),
        .addr_i (addr_i),
        .state_o(state),
        .loc_o  (loc)
    );

    alias_dec_out #(
        .RAM_AW(RAM_AW),
        .ROM_AW(ROM_AW),
        .LOC_W (LOC_W)
    ) u_out (
        .state_i         (state),
        .loc_i           (loc),
        .ram_sel_o       (ram_sel_o),
        .ram_we_o        (ram_we_o),
        .ram_addr_o      (ram_addr_o),
        .rom_sel_o       (rom_sel_o),
        .rom_addr_o      (rom_addr_o),
        .rom_wr_ignored_o(rom_wr_ignored_o)
    );

endmodule

// File: rtl/alias_dec_chk.sv
module alias_dec_chk #(
    parameter int ADDR_W = 32,
    parameter int RAM_AW = 20,
    parameter int ROM_AW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_i,
    input logic              we_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              ram_sel_o,
    input logic              ram_we_o,
    input logic [RAM_AW-1:0] ram_addr_o,
    input logic              rom_sel_o,
    input logic [ROM_AW-1:0] rom_addr_o,
    input logic              rom_wr_ignored_o
);

    // R9
    one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_sel_o, rom_sel_o}));

    // R2
    ram_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !addr_i[ADDR_W-1]) |=> (ram_sel_o && !rom_sel_o));

    // R3
    rom_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && addr_i[ADDR_W-1]) |=> (rom_sel_o && !ram_sel_o));

    // R4
    ram_loc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !addr_i[ADDR_W-1]) |=> (ram_addr_o == $past(addr_i[RAM_AW-1:0])));

    // R5
    rom_loc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && addr_i[ADDR_W-1]) |=> (rom_addr_o == $past(addr_i[ROM_AW-1:0])));

    // R6
    ram_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we_o |-> (ram_sel_o && $past(req_i && we_i)));

    // R7
    rom_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && we_i && addr_i[ADDR_W-1]) |=> (rom_wr_ignored_o && !ram_we_o));

    // R8
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !(ram_sel_o || rom_sel_o || ram_we_o || rom_wr_ignored_o));

endmodule

bind alias_decoder alias_dec_chk #(
    .ADDR_W(ADDR_W),
    .RAM_AW(RAM_AW),
    .ROM_AW(ROM_AW)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_i           (req_i),
    .we_i            (we_i),
    .addr_i          (addr_i),
    .ram_sel_o       (ram_sel_o),
    .ram_we_o        (ram_we_o),
    .ram_addr_o      (ram_addr_o),
    .rom_sel_o       (rom_sel_o),
    .rom_addr_o      (rom_addr_o),
    .rom_wr_ignored_o(rom_wr_ignored_o)
);

// File: tb/alias_decoder_tb.sv
module alias_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        we_i = 1'b0;
    logic [31:0] addr_i = '0;
    logic        ram_sel_o, ram_we_o, rom_sel_o, rom_wr_ignored_o;
    logic [19:0] ram_addr_o;
    logic [15:0] rom_addr_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    alias_decoder u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_i           (req_i),
        .we_i            (we_i),
        .addr_i          (addr_i),
        .ram_sel_o       (ram_sel_o),
        .ram_we_o        (ram_we_o),
        .ram_addr_o      (ram_addr_o),
        .rom_sel_o       (rom_sel_o),
        .rom_addr_o      (rom_addr_o),
        .rom_wr_ignored_o(rom_wr_ignored_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, capture at the rising edge, sample at the next falling edge
    task automatic step(input logic r, input logic w, input logic [31:0] a);
        req_i  = r;
        we_i   = w;
        addr_i = a;
        @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 ram_sel in reset", {31'd0, ram_sel_o}, 32'd0);
        chk("R1 rom_sel in reset", {31'd0, rom_sel_o}, 32'd0);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 32'h0);
        chk("R1 flags after reset", {28'd0, ram_sel_o, rom_sel_o, ram_we_o, rom_wr_ignored_o}, 32'd0);
    endtask

    task automatic t_ram_alias;
        step(1'b1, 1'b0, 32'h0010_0000);
        chk("R2 ram_sel", {30'd0, ram_sel_o, rom_sel_o}, 32'h2);
        chk("R4 alias 0x00100000", {12'd0, ram_addr_o}, 32'h0);
        step(1'b1, 1'b0, 32'h7FF1_2345);
        chk("R4 alias 0x7FF12345", {12'd0, ram_addr_o}, 32'h12345);
        chk("R6 no we on read", {31'd0, ram_we_o}, 32'd0);
    endtask

    task automatic t_rom_alias;
        step(1'b1, 1'b0, 32'hFFFF_FFF0);
        chk("R3 rom_sel", {30'd0, ram_sel_o, rom_sel_o}, 32'h1);
        chk("R5 reset vector", {16'd0, rom_addr_o}, 32'hFFF0);
        chk("R7 no ignore on read", {31'd0, rom_wr_ignored_o}, 32'd0);
        step(1'b1, 1'b0, 32'h8001_ABCD);
        chk("R5 alias 0x8001ABCD", {16'd0, rom_addr_o}, 32'hABCD);
    endtask

    task automatic t_ram_write;
        step(1'b1, 1'b1, 32'h000F_FFFF);
        chk("R6 ram write", {30'd0, ram_sel_o, ram_we_o}, 32'h3);
        chk("R4 top ram loc", {12'd0, ram_addr_o}, 32'hFFFFF);
    endtask

    task automatic t_rom_write;
        step(1'b1, 1'b1, 32'hC000_1234);
        chk("R7 rom write flags", {29'd0, rom_sel_o, ram_we_o, rom_wr_ignored_o}, 32'h5);
        step(1'b0, 1'b0, 32'h0);
        chk("R7 ignore lasts one cycle", {31'd0, rom_wr_ignored_o}, 32'd0);
    endtask

    task automatic t_idle;
        step(1'b0, 1'b1, 32'h8000_0000);
        chk("R8 strobe low", {28'd0, ram_sel_o, rom_sel_o, ram_we_o, rom_wr_ignored_o}, 32'd0);
    endtask

    task automatic t_back_to_back;
        step(1'b1, 1'b0, 32'h8000_0010);
        chk("R9 b2b first rom", {30'd0, ram_sel_o, rom_sel_o}, 32'h1);
        step(1'b1, 1'b1, 32'h0000_0020);
        chk("R9 b2b second ram", {29'd0, ram_sel_o, rom_sel_o, ram_we_o}, 32'h5);
        chk("R9 b2b ram loc", {12'd0, ram_addr_o}, 32'h20);
        step(1'b1, 1'b1, 32'hFFFF_0001);
        chk("R9 b2b third rom wr", {28'd0, ram_sel_o, rom_sel_o, ram_we_o, rom_wr_ignored_o}, 32'h5);
        step(1'b0, 1'b0, 32'h0);
        chk("R9 b2b drained", {30'd0, ram_sel_o, rom_sel_o}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_ram_alias();
        t_rom_alias();
        t_ram_write();
        t_rom_write();
        t_idle();
        t_back_to_back();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule